// File: doc/BRIEF.md
# Stochastic memristor emulator controller

This block is the digital control path of a memristor emulator built around a switched-capacitor variable resistor. Two signed binary samples of the terminal voltages arrive every clock from external converters. Each sample is turned into its own bipolar stochastic bitstream. The difference of the two streams is integrated in a saturating up/down counter, and that counter holds the emulated flux.

The magnitude of the flux, multiplied by a programmable gain, sets a stochastic duty stream. This stream drives two non-overlapping switch-control outputs for the capacitor network. Because the equivalent conductance of the network rises linearly with the duty cycle, the conductance follows the flux and gives the memristive behaviour. Once gain times flux reaches full scale, the duty stream stays high and the conductance stops rising.

Top module: `memr_emu_ctrl`

## Requirements
- R1: A synchronous active-high reset loads the three random sources with their seeds, clears the flux to 0 and drives both switch outputs low. The seeds are 0xACE1 for voltage a, 0x1D2C for voltage b and 0x5A5A for the duty source.
- R2: Each random source is a 16-bit shift register that moves left every cycle, with bit 0 taking the XOR of the tapped bits. The tapped bits are 15, 14, 12 and 3 for voltage a, 15, 13, 12 and 10 for voltage b, and 15, 14, 11 and 9 for the duty source. A source never reaches the all-zero state.
- R3: A voltage code is signed 16-bit two's complement. Its offset form is the code with bit 15 inverted, and its stream bit is 1 when the offset form is greater than or equal to the current random value of its source. As a result, code 0x7FFF always gives 1 and code 0x8000 always gives 0.
- R4: On each clock the flux rises by 1 when the a bit is 1 and the b bit is 0. It falls by 1 when the a bit is 0 and the b bit is 1. It holds when the two bits are equal.
- R5: The flux is signed 16-bit and saturates at 32767 and at -32768 instead of wrapping.
- R6: The duty level is the lesser of gain times the absolute value of the flux and 65535. The gain is unsigned, and the absolute value of -32768 is 32768. The duty bit is 1 when this level is greater than or equal to the duty source value. The duty bit is registered once.
- R7: When the duty level is 65535, the duty bit is 1 on every cycle. When the gain is 0, the duty bit is 0 on every cycle.
- R8: sw_a is high only when the duty bit was 1 in both of the two latest evaluations. sw_b is high only when the duty bit was 0 in both. The two outputs are never high together.
- R9: On every change of the duty bit, both switch outputs are low for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| va_code | input | 16 | Signed sample of terminal voltage a |
| vb_code | input | 16 | Signed sample of terminal voltage b |
| gain_k | input | GAIN_W (8) | Unsigned flux-to-duty gain |
| flux_o | output | 16 | Signed flux counter value |
| sw_a | output | 1 | Switch control, phase one |
| sw_b | output | 1 | Switch control, complementary phase |

## Verification
Every block's state reaches the ports within one or two cycles. A random source with a wrong seed or wrong taps changes which bits the comparators produce. This shows on flux_o within a few cycles under mid-range codes, and on the switch outputs under a mid-range duty level. A wrong step or a wrapping counter shows on flux_o at the edge after the step. A wrong duty scale or clamp shows at the switch outputs one or two cycles later. The bench keeps its own per-cycle model of every source, the counter and the switch drive, and compares all outputs on every cycle. It also drives the counter into both saturation limits and holds the gain at zero and at full scale.

// File: rtl/memr_pkg.sv
package memr_pkg;

  localparam int SC_W       = 16;
  localparam int GAIN_MAX_W = 16;

  typedef logic [SC_W-1:0]        word_t;
  typedef logic signed [SC_W-1:0] flux_t;

  localparam flux_t FLUX_MAX = {1'b0, {(SC_W-1){1'b1}}};
  localparam flux_t FLUX_MIN = {1'b1, {(SC_W-1){1'b0}}};
  localparam word_t SIGN_BIT = {1'b1, {(SC_W-1){1'b0}}};

  // One left shift of a Fibonacci register, feedback into bit 0
  function automatic word_t lfsr_next(word_t s, word_t mask);
    return {s[SC_W-2:0], ^(s & mask)};
  endfunction

  // Bipolar code to unsigned offset form
  function automatic word_t bip_offset(word_t code);
    return code ^ SIGN_BIT;
  endfunction

  // Saturating unit step of the flux integrator
  function automatic flux_t flux_step(flux_t f, logic up, logic dn);
    flux_t r;
    r = f;
    if (up && !dn) begin
      if (f != FLUX_MAX) r = f + flux_t'(1);
    end else if (dn && !up) begin
      if (f != FLUX_MIN) r = f - flux_t'(1);
    end
    return r;
  endfunction

  // Absolute value as unsigned (most negative maps to 2^(SC_W-1))
  function automatic word_t flux_mag(flux_t f);
    word_t r;
    if (f[SC_W-1]) r = word_t'(~f) + word_t'(1);
    else           r = word_t'(f);
    return r;
  endfunction

  // Gain times magnitude, clamped to full scale
  function automatic word_t duty_scale(word_t mag, logic [GAIN_MAX_W-1:0] k);
    logic [SC_W+GAIN_MAX_W-1:0] prod;
    prod = {{GAIN_MAX_W{1'b0}}, mag} * {{SC_W{1'b0}}, k};
    if (|prod[SC_W+GAIN_MAX_W-1:SC_W]) return '1;
    return prod[SC_W-1:0];
  endfunction

endpackage

// File: rtl/memr_lfsr.sv
module memr_lfsr
  import memr_pkg::*;
#(
  parameter word_t SEED = 16'hACE1,
  parameter word_t MASK = 16'hD008
) (
  input  logic  clk,
  input  logic  rst,
  output word_t state_o
);

  word_t state_q;

  always_ff @(posedge clk) begin
    if (rst) state_q <= SEED;
    else     state_q <= lfsr_next(state_q, MASK);
  end

  assign state_o = state_q;

  // R2
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    state_q != '0);

endmodule

// File: rtl/memr_b2s.sv
module memr_b2s
  import memr_pkg::*;
(
  input  word_t code_i,
  input  word_t rnd_i,
  output logic  bit_o
);

  word_t offset;

  always_comb begin
    offset = bip_offset(code_i);
    bit_o  = (offset >= rnd_i);
  end

endmodule

// File: rtl/memr_flux_integ.sv
module memr_flux_integ
  import memr_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  up_i,
  input  logic  dn_i,
  output flux_t flux_o
);

  flux_t flux_q;

  always_ff @(posedge clk) begin
    if (rst) flux_q <= '0;
    else     flux_q <= flux_step(flux_q, up_i, dn_i);
  end

  assign flux_o = flux_q;

  // R4
  flux_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (up_i == dn_i) |=> (flux_q == $past(flux_q)));

  // R4
  flux_up_chk: assert property (@(posedge clk) disable iff (rst)
    (up_i && !dn_i && flux_q != FLUX_MAX) |=> (flux_q == $past(flux_q) + flux_t'(1)));

  // R5
  no_wrap_hi_chk: assert property (@(posedge clk) disable iff (rst)
    (flux_q == FLUX_MAX) |=> (flux_q != FLUX_MIN));

  // R5
  no_wrap_lo_chk: assert property (@(posedge clk) disable iff (rst)
    (flux_q == FLUX_MIN) |=> (flux_q != FLUX_MAX));

endmodule

// File: rtl/memr_duty_gen.sv
module memr_duty_gen
  import memr_pkg::*;
#(
  parameter int GAIN_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  flux_t             flux_i,
  input  logic [GAIN_W-1:0] gain_i,
  input  word_t             rnd_i,
  output logic              duty_d_o,
  output logic              duty_q_o
);

  logic [GAIN_MAX_W-1:0] gain_ext;
  word_t                 level;
  logic                  level_full;
  logic                  duty_q;

  always_comb begin
    gain_ext             = '0;
    gain_ext[GAIN_W-1:0] = gain_i;
    level                = duty_scale(flux_mag(flux_i), gain_ext);
    level_full           = (level == '1);
    duty_d_o             = (level >= rnd_i);
  end

  always_ff @(posedge clk) begin
    if (rst) duty_q <= 1'b0;
    else     duty_q <= duty_d_o;
  end

  assign duty_q_o = duty_q;

  // R7
  duty_full_chk: assert property (@(posedge clk) disable iff (rst)
    level_full |=> duty_q);

  // R7
  duty_zero_gain_chk: assert property (@(posedge clk) disable iff (rst)
    (gain_i == '0) |=> !duty_q);

  // R6
  duty_zero_flux_chk: assert property (@(posedge clk) disable iff (rst)
    (flux_i == '0) |=> !duty_q);

endmodule

// File: rtl/memr_sw_drv.sv
module memr_sw_drv (
  input  logic clk,
  input  logic rst,
  input  logic duty_d_i,
  input  logic duty_q_i,
  output logic sw_a_o,
  output logic sw_b_o
);

  logic sw_a_q;
  logic sw_b_q;
  logic edge_seen;

  assign edge_seen = (duty_d_i != duty_q_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      sw_a_q <= 1'b0;
      sw_b_q <= 1'b0;
    end else begin
      sw_a_q <= duty_d_i & duty_q_i;
      sw_b_q <= ~duty_d_i & ~duty_q_i;
    end
  end

  assign sw_a_o = sw_a_q;
  assign sw_b_o = sw_b_q;

  // R8
  no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    !(sw_a_q && sw_b_q));

  // R9
  dead_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    edge_seen |=> (!sw_a_q && !sw_b_q));

  // R8
  steady_high_chk: assert property (@(posedge clk) disable iff (rst)
    (duty_d_i && duty_q_i) |=> sw_a_q);

endmodule

// File: rtl/memr_emu_ctrl.sv
module memr_emu_ctrl
  import memr_pkg::*;
#(
  parameter int            GAIN_W    = 8,
  parameter logic [47:0]   RNG_SEEDS = {16'h5A5A, 16'h1D2C, 16'hACE1},
  parameter logic [47:0]   RNG_MASKS = {16'hCA00, 16'hB400, 16'hD008}
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [15:0]       va_code,
  input  logic [15:0]       vb_code,
  input  logic [GAIN_W-1:0] gain_k,
  output logic [15:0]       flux_o,
  output logic              sw_a,
  output logic              sw_b
);

  localparam int N_RNG  = 3;
  localparam int RNG_VA = 0;
  localparam int RNG_VB = 1;
  localparam int RNG_DT = 2;

  word_t rnd [N_RNG];
  logic  bit_a;
  logic  bit_b;
  flux_t flux;
  logic  duty_d;
  logic  duty_q;

  for (genvar g = 0; g < N_RNG; g++) begin : gen_rng
    memr_lfsr #(
      .SEED (RNG_SEEDS[g*SC_W +: SC_W]),
      .MASK (RNG_MASKS[g*SC_W +: SC_W])
    ) u_lfsr (
      .clk     (clk),
      .rst     (rst),
      .state_o (rnd[g])
    );
  end

  memr_b2s u_b2s_a (
    .code_i (va_code),
    .rnd_i  (rnd[RNG_VA]),
    .bit_o  (bit_a)
  );

  memr_b2s u_b2s_b (
    .code_i (vb_code),
    .rnd_i  (rnd[RNG_VB]),
    .bit_o  (bit_b)
  );

  memr_flux_integ u_integ (
    .clk    (clk),
    .rst    (rst),
    .up_i   (bit_a),
    .dn_i   (bit_b),
    .flux_o (flux)
  );

  memr_duty_gen #(
    .GAIN_W (GAIN_W)
  ) u_duty (
    .clk      (clk),
    .rst      (rst),
    .flux_i   (flux),
    .gain_i   (gain_k),
    .rnd_i    (rnd[RNG_DT]),
    .duty_d_o (duty_d),
    .duty_q_o (duty_q)
  );

  memr_sw_drv u_drv (
    .clk      (clk),
    .rst      (rst),
    .duty_d_i (duty_d),
    .duty_q_i (duty_q),
    .sw_a_o   (sw_a),
    .sw_b_o   (sw_b)
  );

  assign flux_o = flux;

  // R3
  code_top_chk: assert property (@(posedge clk) disable iff (rst)
    (va_code == 16'h7FFF) |-> bit_a);

  // R3
  code_bottom_chk: assert property (@(posedge clk) disable iff (rst)
    (vb_code == 16'h8000) |-> !bit_b);

  // R4
  ramp_chk: assert property (@(posedge clk) disable iff (rst)
    (va_code == 16'h7FFF && vb_code == 16'h8000 && flux != FLUX_MAX)
      |=> (flux == $past(flux) + flux_t'(1)));

endmodule

// File: tb/memr_emu_ctrl_tb.sv
module memr_emu_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int N_VEC      = 6;

  // fields: va, vb, gain, cycles
  localparam logic [63:0] VEC [N_VEC] = '{
    {16'h7FFF, 16'h8000, 16'd1,   16'd200},
    {16'h0000, 16'h0000, 16'd255, 16'd300},
    {16'h4000, 16'hC000, 16'd64,  16'd400},
    {16'h8000, 16'h7FFF, 16'd4,   16'd600},
    {16'h7FFF, 16'h7FFF, 16'd16,  16'd100},
    {16'h1234, 16'hF000, 16'd0,   16'd100}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] va = '0;
  logic [15:0] vb = '0;
  logic [7:0]  k  = '0;
  logic [15:0] flux;
  logic        swa;
  logic        swb;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [15:0] mla, mlb, mlc;
  int          mflux;
  bit          md, mswa, mswb;

  always #(CLK_PERIOD/2) clk = ~clk;

  memr_emu_ctrl u_dut (
    .clk     (clk),
    .rst     (rst),
    .va_code (va),
    .vb_code (vb),
    .gain_k  (k),
    .flux_o  (flux),
    .sw_a    (swa),
    .sw_b    (swb)
  );

  function automatic logic [15:0] nx(logic [15:0] s, int which);
    logic fb;
    case (which)
      0:       fb = s[15] ^ s[14] ^ s[12] ^ s[3];
      1:       fb = s[15] ^ s[13] ^ s[12] ^ s[10];
      default: fb = s[15] ^ s[14] ^ s[11] ^ s[9];
    endcase
    return {s[14:0], fb};
  endfunction

  task automatic model_reset();
    mla = 16'hACE1; mlb = 16'h1D2C; mlc = 16'h5A5A;
    mflux = 0; md = 1'b0; mswa = 1'b0; mswb = 1'b0;
  endtask

  task automatic model_step();
    logic [15:0] ua, ub;
    bit ba, bb, d;
    int mag;
    ua = {~va[15], va[14:0]};
    ub = {~vb[15], vb[14:0]};
    ba = (ua >= mla);
    bb = (ub >= mlb);
    mag = int'(k) * ((mflux < 0) ? -mflux : mflux);
    if (mag > 65535) mag = 65535;
    d = (mag >= int'(mlc));
    mswa = d & md;
    mswb = !d & !md;
    md = d;
    if (ba && !bb && mflux < 32767) mflux = mflux + 1;
    else if (!ba && bb && mflux > -32768) mflux = mflux - 1;
    mla = nx(mla, 0); mlb = nx(mlb, 1); mlc = nx(mlc, 2);
  endtask

  task automatic tick();
    @(posedge clk);
    if (rst) model_reset();
    else     model_step();
    @(negedge clk);
  endtask

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cmp_all(string req);
    check(int'($signed(flux)) == mflux, req, "flux", int'($signed(flux)), mflux);
    check(swa == mswa, "R6", "sw_a", int'(swa), int'(mswa));
    check(swb == mswb, "R9", "sw_b", int'(swb), int'(mswb));
    check(!(swa && swb), "R8", "overlap", int'(swa && swb), 0);
  endtask

  initial begin
    int start;
    bit saw_high;
    @(negedge clk);
    rst = 1'b1;
    repeat (3) tick();
    // R1 reset state
    check(flux == 16'd0, "R1", "flux at reset", int'($signed(flux)), 0);
    check(swa == 1'b0 && swb == 1'b0, "R1", "switches at reset", int'({swa, swb}), 0);
    rst = 1'b0;

    for (int i = 0; i < N_VEC; i++) begin
      va = VEC[i][63:48];
      vb = VEC[i][47:32];
      k  = VEC[i][23:16];
      start = int'($signed(flux));
      saw_high = 1'b0;
      for (int j = 0; j < int'(VEC[i][15:0]); j++) begin
        tick();
        cmp_all("R4");
        if (swa) saw_high = 1'b1;
      end
      // R3 extreme codes give deterministic streams
      if (i == 0) check(int'($signed(flux)) == start + 200, "R3", "ramp up", int'($signed(flux)), start + 200);
      if (i == 3) check(int'($signed(flux)) == start - 600, "R3", "ramp down", int'($signed(flux)), start - 600);
      // R4 equal bits hold
      if (i == 4) check(int'($signed(flux)) == start, "R4", "hold", int'($signed(flux)), start);
      // R7 zero gain keeps duty low
      if (i == 5) check(!saw_high, "R7", "zero gain sw_a", int'(saw_high), 0);
    end

    // R5 positive saturation, then R7 full scale with gain 3
    va = 16'h7FFF; vb = 16'h8000; k = 8'd3;
    repeat (33400) tick();
    check(int'($signed(flux)) == 32767, "R5", "positive limit", int'($signed(flux)), 32767);
    cmp_all("R5");
    for (int j = 0; j < 20; j++) begin
      tick();
      check(swa == 1'b1 && swb == 1'b0, "R7", "full scale", int'({swa, swb}), 2);
    end

    // R5 negative saturation with gain 1
    va = 16'h8000; vb = 16'h7FFF; k = 8'd1;
    repeat (65700) tick();
    check(int'($signed(flux)) == -32768, "R5", "negative limit", int'($signed(flux)), -32768);
    cmp_all("R5");
    // R6 magnitude 32768 times 2 clamps to full scale
    k = 8'd2;
    repeat (2) tick();
    for (int j = 0; j < 10; j++) begin
      tick();
      check(swa == 1'b1 && swb == 1'b0, "R6", "clamp at minimum", int'({swa, swb}), 2);
    end

    // R1 reset in mid-run, then R2 sources restart from seeds
    rst = 1'b1;
    repeat (2) tick();
    check(flux == 16'd0, "R1", "flux after reset", int'($signed(flux)), 0);
    check(swa == 1'b0 && swb == 1'b0, "R1", "switches after reset", int'({swa, swb}), 0);
    rst = 1'b0;
    va = 16'h2000; vb = 16'hE000; k = 8'd200;
    for (int j = 0; j < 60; j++) begin
      tick();
      cmp_all("R2");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (199000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule